// File: doc/BRIEF.md
# Programmable IDE PIO Strobe Timer

This block drives the active-low read and write command strobes of a programmed-I/O transfer on one IDE channel. It runs on the local-bus clock. A transfer request selects one of several 8-bit timing registers. One nibble of the selected register sets how many clocks the strobe stays asserted. The other nibble sets how many clocks must pass before the next strobe may begin. Both counts are stored as a ceiling minus the wanted count, so the all-zero field is always the slowest setting.

Two register variants are built from one parameter. The wide variant uses a 4-bit active field. The narrow variant uses a 3-bit active field, and its decode follows a bus-speed strap. A request that arrives while a cycle is running is held, and it is served the moment recovery expires. A one-clock done pulse marks the release of each strobe.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, rd_n and wr_n are high and done is low. Every timing register holds its slowest encoding: 17 active and 15 recovery clocks in the wide variant; 9/15 clocks (bus_slow=1) or 8/18 clocks (bus_slow=0) in the narrow variant.
- R2: A transfer with req_rd=1 drives only rd_n low, and one with req_rd=0 drives only wr_n low. The two strobes are never low together.
- R3: In the wide variant the strobe stays low for exactly 17 minus timing bits [3:0] clocks.
- R4: In the wide variant the recovery is 15 minus timing bits [7:4] clocks, raised to 2 when that gives less than 2 (upper-nibble values 14 and 15).
- R5: In the narrow variant with bus_slow=1, active is 9 minus bits [2:0] and recovery is 15 minus bits [7:4]. Bit 3 has no effect on either count.
- R6: In the narrow variant with bus_slow=0, active is 8 minus bits [2:0] and recovery is 18 minus bits [7:4].
- R7: done is high for exactly one clock per transfer, and that is the first clock in which the strobe is high again.
- R8: A request sampled on a clock edge while the block is idle makes the strobe low from that edge, so the first low clock is the clock right after the request clock.
- R9: A request that arrives during the active or recovery phase is held (one deep). When a request is pending, the strobes stay high for exactly max(recovery,1) clocks between the two strobes, counting the done clock.
- R10: cfg_we writes cfg_data into timer cfg_sel. A transfer uses timer req_sel as it stood when the transfer started. The recovery after a strobe comes from that same strobe's timer.
- R11: Writing a timer while its cycle is running leaves that cycle's active and recovery counts unchanged. The new value applies from the next transfer start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_slow | input | 1 | Bus-speed strap: 1 means 33 MHz or less (narrow variant only) |
| req | input | 1 | One-clock transfer request |
| req_rd | input | 1 | Direction of the request: 1 read, 0 write |
| req_sel | input | SEL_W | Timing register governing the request |
| cfg_we | input | 1 | Timing register write enable |
| cfg_sel | input | SEL_W | Timing register being written |
| cfg_data | input | 8 | Timing byte: [3:0] or [2:0] active field, [7:4] recovery field |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock pulse when the strobe is released |

## Verification
Three events can fall on the same clock edge. The last recovery clock can coincide with the start of a held request. A write to the governing timer can coincide with a running cycle. The bench provokes the first by issuing a second request one clock after the first, which is while the first is still active. It judges the result by the exact number of high clocks between the two strobes, including recovery settings of 0 and 1. It provokes the second by rewriting the timer in the middle of a long active phase. It then checks that the current strobe width and recovery keep the old values and that the following strobe uses the new one.

// File: rtl/pio_tmr_pkg.sv
package pio_tmr_pkg;

  // widest count any variant can produce is 18 clocks
  localparam int CNT_MAX = 18;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_CEIL = CNT_W'(CNT_MAX);

  // wide variant decode ceilings
  localparam logic [CNT_W-1:0] WIDE_ACT_TOP = CNT_W'(17);
  localparam logic [CNT_W-1:0] WIDE_REC_TOP = CNT_W'(15);
  localparam logic [CNT_W-1:0] WIDE_REC_MIN = CNT_W'(2);

  // narrow variant decode ceilings, per strap setting
  localparam logic [CNT_W-1:0] NSLOW_ACT_TOP = CNT_W'(9);
  localparam logic [CNT_W-1:0] NSLOW_REC_TOP = CNT_W'(15);
  localparam logic [CNT_W-1:0] NFAST_ACT_TOP = CNT_W'(8);
  localparam logic [CNT_W-1:0] NFAST_REC_TOP = CNT_W'(18);

  // slowest encodings loaded at reset
  localparam logic [7:0] WIDE_SAFE_BYTE   = 8'h00;
  localparam logic [7:0] NARROW_SAFE_BYTE = 8'h08;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACTIVE  = 2'd1,
    PH_RECOVER = 2'd2
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] rec;
  } cycle_len_t;

endpackage

// File: rtl/pio_tmr_regfile.sv
module pio_tmr_regfile #(
  parameter int         NUM     = 4,
  parameter logic [7:0] RST_VAL = 8'h00,
  localparam int        SW      = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [7:0]    wdata,
  input  logic [SW-1:0] rsel,
  output logic [7:0]    rdata
);

  logic [7:0] slot_w [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    logic       hit;
    logic [7:0] val_q;

    assign hit = we && (wsel == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= RST_VAL;
      else if (hit) val_q <= wdata;
    end

    assign slot_w[g] = val_q;
  end

  assign rdata = slot_w[rsel];

  // R10: a write lands in the addressed slot on the next clock
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (slot_w[$past(wsel)] == $past(wdata)));

endmodule

// File: rtl/pio_tmr_decode.sv
module pio_tmr_decode
  import pio_tmr_pkg::*;
#(
  parameter bit NARROW = 1'b0
) (
  input  logic [7:0] tbyte,
  input  logic       bus_slow,
  output cycle_len_t len
);

  logic [CNT_W-1:0] hi_f;
  assign hi_f = CNT_W'(tbyte[7:4]);

  if (NARROW) begin : g_narrow
    logic [CNT_W-1:0] fld;
    logic             unused_fixed_bit;

    assign fld              = CNT_W'(tbyte[2:0]);
    assign unused_fixed_bit = tbyte[3];

    always_comb begin
      if (bus_slow) begin
        len.act = NSLOW_ACT_TOP - fld;
        len.rec = NSLOW_REC_TOP - hi_f;
      end else begin
        len.act = NFAST_ACT_TOP - fld;
        len.rec = NFAST_REC_TOP - hi_f;
      end
    end
  end else begin : g_wide
    logic [CNT_W-1:0] rec_raw;
    logic             unused_strap;

    assign unused_strap = bus_slow;

    always_comb begin
      rec_raw = WIDE_REC_TOP - hi_f;
      len.act = WIDE_ACT_TOP - CNT_W'(tbyte[3:0]);
      len.rec = (rec_raw < WIDE_REC_MIN) ? WIDE_REC_MIN : rec_raw;
    end
  end

endmodule

// File: rtl/pio_tmr_seq.sv
module pio_tmr_seq
  import pio_tmr_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_rd,
  input  logic [SEL_W-1:0] req_sel,
  input  cycle_len_t       len_in,
  output logic [SEL_W-1:0] look_sel,
  output logic             rd_n,
  output logic             wr_n,
  output logic             done
);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rec_q, rec_d;
  logic             dir_q, dir_d;
  logic             pend_q, pend_d;
  logic             pend_rd_q, pend_rd_d;
  logic [SEL_W-1:0] pend_sel_q, pend_sel_d;
  logic             rd_n_q, wr_n_q, done_q;
  logic             eff_rd, start_ok, start, fin;

  // request source: the held request has priority over a live one
  always_comb begin
    look_sel = pend_q ? pend_sel_q : req_sel;
    eff_rd   = pend_q ? pend_rd_q  : req_rd;
    start_ok = (ph_q == PH_IDLE) || ((ph_q == PH_RECOVER) && (cnt_q == '0));
    start    = start_ok && (pend_q || req);
  end

  // one-deep holding slot
  always_comb begin
    pend_d     = pend_q;
    pend_rd_d  = pend_rd_q;
    pend_sel_d = pend_sel_q;
    if (start && !pend_q) begin
      pend_d = 1'b0;
    end else if (req && (!pend_q || start)) begin
      pend_d     = 1'b1;
      pend_rd_d  = req_rd;
      pend_sel_d = req_sel;
    end else if (start) begin
      pend_d = 1'b0;
    end
  end

  // phase sequencing
  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    rec_d = rec_q;
    dir_d = dir_q;
    fin   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        ph_d = PH_IDLE;
      end
      PH_ACTIVE: begin
        if (cnt_q == '0) begin
          fin = 1'b1;
          if (rec_q == '0) begin
            ph_d = PH_IDLE;
          end else begin
            ph_d  = PH_RECOVER;
            cnt_d = rec_q - CNT_ONE;
          end
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      PH_RECOVER: begin
        if (cnt_q == '0) ph_d = PH_IDLE;
        else             cnt_d = cnt_q - CNT_ONE;
      end
      default: ph_d = PH_IDLE;
    endcase
    if (start) begin
      ph_d  = PH_ACTIVE;
      cnt_d = len_in.act - CNT_ONE;
      rec_d = len_in.rec;
      dir_d = eff_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      cnt_q      <= '0;
      rec_q      <= '0;
      dir_q      <= 1'b0;
      pend_q     <= 1'b0;
      pend_rd_q  <= 1'b0;
      pend_sel_q <= '0;
      rd_n_q     <= 1'b1;
      wr_n_q     <= 1'b1;
      done_q     <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      cnt_q      <= cnt_d;
      rec_q      <= rec_d;
      dir_q      <= dir_d;
      pend_q     <= pend_d;
      pend_rd_q  <= pend_rd_d;
      pend_sel_q <= pend_sel_d;
      rd_n_q     <= !((ph_d == PH_ACTIVE) && dir_d);
      wr_n_q     <= !((ph_d == PH_ACTIVE) && !dir_d);
      done_q     <= fin;
    end
  end

  assign rd_n = rd_n_q;
  assign wr_n = wr_n_q;
  assign done = done_q;

  // R2: strobes are mutually exclusive
  assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R7: done only in the clock the strobe is released
  assert_done_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n && $past(!rd_n || !wr_n)));

  // R9: a held request is never left waiting in idle
  assert_pending_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_IDLE) && pend_q) |=> (ph_q == PH_ACTIVE));

  // R3: decoded counts handed to a new cycle are in the legal span
  assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ((len_in.act != '0) && (len_in.act <= CNT_CEIL) && (len_in.rec <= CNT_CEIL)));

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_tmr_pkg::*;
#(
  parameter int  NUM_TIMERS = 4,
  parameter bit  NARROW     = 1'b0,
  localparam int SEL_W      = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_slow,
  input  logic             req,
  input  logic             req_rd,
  input  logic [SEL_W-1:0] req_sel,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [7:0]       cfg_data,
  output logic             rd_n,
  output logic             wr_n,
  output logic             done
);

  localparam logic [7:0] SAFE_BYTE = NARROW ? NARROW_SAFE_BYTE : WIDE_SAFE_BYTE;

  logic [1:0]       rst_pipe_q;
  logic             rst_core_n;
  logic [SEL_W-1:0] look_sel;
  logic [7:0]       look_byte;
  cycle_len_t       look_len;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  pio_tmr_regfile #(
    .NUM     (NUM_TIMERS),
    .RST_VAL (SAFE_BYTE)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (cfg_we),
    .wsel  (cfg_sel),
    .wdata (cfg_data),
    .rsel  (look_sel),
    .rdata (look_byte)
  );

  pio_tmr_decode #(
    .NARROW (NARROW)
  ) u_decode (
    .tbyte    (look_byte),
    .bus_slow (bus_slow),
    .len      (look_len)
  );

  pio_tmr_seq #(
    .SEL_W (SEL_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .req      (req),
    .req_rd   (req_rd),
    .req_sel  (req_sel),
    .len_in   (look_len),
    .look_sel (look_sel),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .done     (done)
  );

endmodule

// File: tb/tb_pio_strobe_timer.sv
module strobe_mon (
  input logic clk,
  input logic en,
  input logic rd_n,
  input logic wr_n,
  input logic done
);
  int   ncyc = 0;
  int   lo = 0;
  int   hi = 0;
  int   last_act = 0;
  int   last_gap = 0;
  int   first_low = 0;
  int   dones = 0;
  int   errs = 0;
  logic last_rd = 1'b0;
  logic prev = 1'b0;
  logic s;

  always @(negedge clk) begin
    ncyc++;
    if (en) begin
      s = !(rd_n && wr_n);
      if (!rd_n && !wr_n) errs++;
      if (done) dones++;
      if (s && !prev) begin
        last_gap  = hi;
        lo        = 1;
        first_low = ncyc;
        last_rd   = !rd_n;
        if (done) errs++;
      end else if (s) begin
        lo++;
        if (done) errs++;
      end else if (prev) begin
        last_act = lo;
        hi       = 1;
        if (!done) errs++;
      end else begin
        hi++;
        if (done) errs++;
      end
      prev = s;
    end
  end
endmodule

module tb_pio_strobe_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b1;
  logic [1:0] reqv = 2'b00;
  logic [1:0] wev = 2'b00;
  logic       rrd = 1'b0;
  logic [1:0] rsel = 2'd0;
  logic [1:0] wsel = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic       rd_n0, wr_n0, done0, rd_n1, wr_n1, done1;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pio_strobe_timer #(.NUM_TIMERS(4), .NARROW(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_slow(strap), .req(reqv[0]), .req_rd(rrd),
    .req_sel(rsel), .cfg_we(wev[0]), .cfg_sel(wsel), .cfg_data(wdata),
    .rd_n(rd_n0), .wr_n(wr_n0), .done(done0));

  pio_strobe_timer #(.NUM_TIMERS(4), .NARROW(1'b1)) dut_nar (
    .clk(clk), .rst_n(rst_n), .bus_slow(strap), .req(reqv[1]), .req_rd(rrd),
    .req_sel(rsel), .cfg_we(wev[1]), .cfg_sel(wsel), .cfg_data(wdata),
    .rd_n(rd_n1), .wr_n(wr_n1), .done(done1));

  strobe_mon m0 (.clk(clk), .en(rst_n), .rd_n(rd_n0), .wr_n(wr_n0), .done(done0));
  strobe_mon m1 (.clk(clk), .en(rst_n), .rd_n(rd_n1), .wr_n(wr_n1), .done(done1));

  // {narrow, strap, rd, byte, expected active, expected high gap}
  localparam int NV = 15;
  localparam logic [26:0] VECS [NV] = '{
    {1'b0, 1'b0, 1'b1, 8'h00, 8'd17, 8'd15},
    {1'b0, 1'b0, 1'b0, 8'h0F, 8'd2,  8'd15},
    {1'b0, 1'b0, 1'b1, 8'h5A, 8'd7,  8'd10},
    {1'b0, 1'b0, 1'b0, 8'hD3, 8'd14, 8'd2},
    {1'b0, 1'b0, 1'b1, 8'hE0, 8'd17, 8'd2},
    {1'b0, 1'b0, 1'b0, 8'hF7, 8'd10, 8'd2},
    {1'b1, 1'b1, 1'b1, 8'h08, 8'd9,  8'd15},
    {1'b1, 1'b1, 1'b0, 8'h0F, 8'd2,  8'd15},
    {1'b1, 1'b1, 1'b1, 8'hF5, 8'd4,  8'd1},
    {1'b1, 1'b1, 1'b0, 8'hE2, 8'd7,  8'd1},
    {1'b1, 1'b1, 1'b1, 8'h33, 8'd6,  8'd12},
    {1'b1, 1'b1, 1'b0, 8'h3B, 8'd6,  8'd12},
    {1'b1, 1'b0, 1'b1, 8'h08, 8'd8,  8'd18},
    {1'b1, 1'b0, 1'b0, 8'hFF, 8'd1,  8'd3},
    {1'b1, 1'b0, 1'b1, 8'h74, 8'd4,  8'd11}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int dones_of(input bit w);
    return w ? m1.dones : m0.dones;
  endfunction

  function automatic int act_of(input bit w);
    return w ? m1.last_act : m0.last_act;
  endfunction

  function automatic int gap_of(input bit w);
    return w ? m1.last_gap : m0.last_gap;
  endfunction

  task automatic write_tmr(input bit w, input logic [1:0] s, input logic [7:0] d);
    wev[w] = 1'b1;
    wsel   = s;
    wdata  = d;
    tick();
    wev[w] = 1'b0;
  endtask

  task automatic fire(input bit w, input logic [1:0] s, input logic rd);
    reqv[w] = 1'b1;
    rsel    = s;
    rrd     = rd;
    tick();
    reqv[w] = 1'b0;
  endtask

  task automatic wait_dones(input bit w, input int target, input string tag);
    for (int i = 0; i < 600 && dones_of(w) < target; i++) tick();
    chk({tag, " done count"}, dones_of(w), target);
  endtask

  task automatic settle();
    repeat (24) tick();
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
    $finish;
  end

  initial begin : main
    int base;
    int n0;
    repeat (3) tick();
    // R1: reset state at the ports
    chk("R1 rd_n reset", int'(rd_n0), 1);
    chk("R1 wr_n reset", int'(wr_n0), 1);
    chk("R1 done reset", int'(done0), 0);
    chk("R1 narrow strobes reset", int'(rd_n1 & wr_n1), 1);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: untouched timers hold the slowest encodings
    base = dones_of(0);
    fire(0, 2'd2, 1'b1);
    fire(0, 2'd2, 1'b1);
    wait_dones(0, base + 2, "R1 wide");
    chk("R1 wide reset active", act_of(0), 17);
    chk("R1 wide reset recovery", gap_of(0), 15);
    settle();
    strap = 1'b1;
    base  = dones_of(1);
    fire(1, 2'd3, 1'b0);
    fire(1, 2'd3, 1'b0);
    wait_dones(1, base + 2, "R1 narrow");
    chk("R1 narrow reset active", act_of(1), 9);
    chk("R1 narrow reset recovery", gap_of(1), 15);
    settle();

    // table of encodings on timer 0 of either variant
    for (int v = 0; v < NV; v++) begin
      bit   w;
      logic rd;
      string ta, tg;
      w     = VECS[v][26];
      strap = VECS[v][25];
      rd    = VECS[v][24];
      ta = w ? (VECS[v][25] ? "R5 active" : "R6 active") : "R3 active";
      tg = w ? (VECS[v][25] ? "R5 recovery" : "R6 recovery") : "R4 recovery";
      write_tmr(w, 2'd0, VECS[v][23:16]);
      tick();
      base = dones_of(w);
      fire(w, 2'd0, rd);
      fire(w, 2'd0, rd);
      wait_dones(w, base + 2, "R9 table");
      chk(ta, act_of(w), int'(VECS[v][15:8]));
      chk({tg, " R9 gap"}, gap_of(w), int'(VECS[v][7:0]));
      chk("R2 direction", int'(w ? m1.last_rd : m0.last_rd), int'(rd));
      settle();
    end

    // R8: latency from an idle request to the strobe
    n0 = m0.ncyc;
    fire(0, 2'd0, 1'b1);
    repeat (3) tick();
    chk("R8 first low clock", m0.first_low, n0 + 2);
    settle();

    // R10: independent timers, recovery from the strobe's own timer
    write_tmr(0, 2'd1, 8'h3C);
    write_tmr(0, 2'd2, 8'h9E);
    tick();
    base = dones_of(0);
    fire(0, 2'd1, 1'b0);
    fire(0, 2'd2, 1'b1);
    wait_dones(0, base + 1, "R10 first");
    chk("R10 timer1 active", act_of(0), 5);
    wait_dones(0, base + 2, "R10 second");
    chk("R10 timer1 recovery", gap_of(0), 12);
    chk("R10 timer2 active", act_of(0), 3);
    chk("R10 timer2 read", int'(m0.last_rd), 1);
    settle();

    // R9: request arriving mid-recovery starts right at its end
    base = dones_of(0);
    fire(0, 2'd1, 1'b1);
    wait_dones(0, base + 1, "R9 late");
    repeat (3) tick();
    fire(0, 2'd1, 1'b1);
    wait_dones(0, base + 2, "R9 late second");
    chk("R9 held through recovery", gap_of(0), 12);
    settle();

    // R11: write during the active phase applies to the next transfer only
    write_tmr(0, 2'd0, 8'h00);
    tick();
    base = dones_of(0);
    fire(0, 2'd0, 1'b0);
    fire(0, 2'd0, 1'b0);
    repeat (3) tick();
    write_tmr(0, 2'd0, 8'h0F);
    wait_dones(0, base + 1, "R11 first");
    chk("R11 active kept", act_of(0), 17);
    wait_dones(0, base + 2, "R11 second");
    chk("R11 recovery kept", gap_of(0), 15);
    chk("R11 new value used", act_of(0), 2);
    settle();

    // R2 and R7 over the whole run
    chk("R2 R7 wide monitor errors", m0.errs, 0);
    chk("R2 R7 narrow monitor errors", m1.errs, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule